// File: doc/BRIEF.md
# Statistics Rollover Interrupt Aggregator

This block collects rollover events from 64 statistics counters into two 32-bit sticky status words, one for the transmit counters and one for the receive counters. Each status word has its own 32-bit enable mask. The enabled bits are reduced into one statistics bit of a host interrupt summary word. The summary word also carries the wake, queue, PHY, frame-error and receive-notification events. Its bits are ORed onto a single interrupt line.

Status bits latch on their event and stay set until software reads the word that holds them. The read returns the value and clears it in the same cycle. A clear mask bit does not stop a status bit from latching. It only keeps that bit out of the summary. Software uses a simple address-decoded read/write port. Reads are combinational while `rdEn` is high, and the clear takes effect at the clock edge that ends the read cycle.

The receive notification "early" bit is delayed by a loadable cycle count. The count starts when reception begins and raises the bit when it expires.

Top module: `stat_irq_top`

## Requirements
- R1: After reset, every register (tx status 0x1D0, tx mask 0x1D4, rx status 0x1D8, rx mask 0x1DC, early delay 0x1E0, summary 0x1E8) reads 0 and `irq` is 0.
- R2: A pulse on `rollEvt[n]` for n in 0..31 sets tx status bit n. A pulse on `rollEvt[n+32]` sets rx status bit n. The bits stay set with no further event.
- R3: Reading a status word returns its bits, then clears all of them at that edge. An event arriving in the same cycle as the read-clear leaves its bit set.
- R4: A status bit latches whatever its mask bit is. Summary bit 16 is 1 exactly when some status bit and its mask bit are both 1.
- R5: Summary bit 20 is the inverse of `wakeN`. Bit 19 follows `qStatIrq`, bit 18 follows `qOvfIrq` and bit 17 follows `phyIrq`, all as levels.
- R6: Summary bits 12 (`txErr`), 11 (`rxErr`) and 8 (`rxFrameDone`) are sticky. Reading the summary word clears them.
- R7: With D in the low 16 bits of 0x1E0, a one-cycle `rxStart` sampled at edge E0 sets summary bit 7 at edge E0+D+1. The bit is sticky and is cleared by a summary read.
- R8: Summary bits 31:21, 15:13, 10:9 and 6:0 always read 0.
- R9: Writes to the status and summary addresses change nothing. The masks and the delay read back what was written, with the delay using 16 bits.
- R10: `irq` is 1 exactly when any summary bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 12 | Byte address of register |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe (clears status on read) |
| rdData | output | 32 | Read data, combinational while rdEn |
| rollEvt | input | 64 | Counter rollover pulses, index = counter |
| wakeN | input | 1 | Active-low power event level |
| qStatIrq | input | 1 | Queue status level |
| qOvfIrq | input | 1 | Queue overflow/underrun level |
| phyIrq | input | 1 | PHY interrupt level |
| txErr | input | 1 | Transmitted-frame error pulse |
| rxErr | input | 1 | Received-frame error pulse |
| rxFrameDone | input | 1 | Whole frame queued pulse |
| rxStart | input | 1 | Reception started pulse |
| irq | output | 1 | Host interrupt |

## Verification
The hardest case to reach from the ports is a rollover event landing in the same cycle as the read that clears its word. The bench holds `rdEn` on the status address and drives `rollEvt` in that same low phase. It then expects the read to return the old value and a second read to still show the new bit. A second hard case is the early-notification timing. The bench pulses `rxStart` once and watches `irq` on each cycle boundary around edge E0+D+1. During that window every other summary source is kept clear.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int NUM_CNT = 64;
  localparam int HALF = NUM_CNT / 2;
  localparam int DLY_W = 16;

  localparam logic [ADDR_W-1:0] ADR_TXST  = 12'h1D0;
  localparam logic [ADDR_W-1:0] ADR_TXMSK = 12'h1D4;
  localparam logic [ADDR_W-1:0] ADR_RXST  = 12'h1D8;
  localparam logic [ADDR_W-1:0] ADR_RXMSK = 12'h1DC;
  localparam logic [ADDR_W-1:0] ADR_DLY   = 12'h1E0;
  localparam logic [ADDR_W-1:0] ADR_SUM   = 12'h1E8;

  localparam int B_WAKE  = 20;
  localparam int B_QSTAT = 19;
  localparam int B_QOVF  = 18;
  localparam int B_PHY   = 17;
  localparam int B_STAT  = 16;
  localparam int B_TXERR = 12;
  localparam int B_RXERR = 11;
  localparam int B_LATE  = 8;
  localparam int B_EARLY = 7;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_TXST, SEL_TXMSK, SEL_RXST, SEL_RXMSK, SEL_DLY, SEL_SUM
  } regSel_e;

  typedef struct packed {
    regSel_e rdSel;
    logic    clrTx;
    logic    clrRx;
    logic    clrSum;
    logic    ldTxMask;
    logic    ldRxMask;
    logic    ldDly;
  } strobe_t;
endpackage

// File: rtl/stat_irq_ctrl.sv
module stat_irq_ctrl
  import stat_irq_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  output strobe_t           strb
);
  regSel_e hit;

  always_comb begin
    unique case (regAddr)
      ADR_TXST:  hit = SEL_TXST;
      ADR_TXMSK: hit = SEL_TXMSK;
      ADR_RXST:  hit = SEL_RXST;
      ADR_RXMSK: hit = SEL_RXMSK;
      ADR_DLY:   hit = SEL_DLY;
      ADR_SUM:   hit = SEL_SUM;
      default:   hit = SEL_NONE;
    endcase
  end

  always_comb begin
    strb          = '0;
    strb.rdSel    = rdEn ? hit : SEL_NONE;
    strb.clrTx    = rdEn && (hit == SEL_TXST);
    strb.clrRx    = rdEn && (hit == SEL_RXST);
    strb.clrSum   = rdEn && (hit == SEL_SUM);
    strb.ldTxMask = wrEn && (hit == SEL_TXMSK);
    strb.ldRxMask = wrEn && (hit == SEL_RXMSK);
    strb.ldDly    = wrEn && (hit == SEL_DLY);
  end
endmodule

// File: rtl/stat_irq_dp.sv
module stat_irq_dp
  import stat_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_CNT-1:0] rollEvt,
  input  logic               wakeN,
  input  logic               qStatIrq,
  input  logic               qOvfIrq,
  input  logic               phyIrq,
  input  logic               txErr,
  input  logic               rxErr,
  input  logic               rxFrameDone,
  input  logic               rxStart,
  output logic [HALF-1:0]    txStat,
  output logic [HALF-1:0]    rxStat,
  output logic [DATA_W-1:0]  summary,
  output logic               irq
);
  logic [HALF-1:0]  txMask, rxMask;
  logic [DLY_W-1:0] dlyReg, dlyCnt;
  logic             dlyRun, earlyFire;
  logic             txErrSt, rxErrSt, lateSt, earlySt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txStat <= '0;
      rxStat <= '0;
    end else begin
      txStat <= (txStat & ~{HALF{strb.clrTx}}) | rollEvt[HALF-1:0];
      rxStat <= (rxStat & ~{HALF{strb.clrRx}}) | rollEvt[NUM_CNT-1:HALF];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txMask <= '0;
      rxMask <= '0;
      dlyReg <= '0;
    end else begin
      if (strb.ldTxMask) txMask <= wrData[HALF-1:0];
      if (strb.ldRxMask) rxMask <= wrData[HALF-1:0];
      if (strb.ldDly)    dlyReg <= wrData[DLY_W-1:0];
    end
  end

  assign earlyFire = dlyRun && (dlyCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dlyRun <= 1'b0;
      dlyCnt <= '0;
    end else if (rxStart) begin
      dlyRun <= 1'b1;
      dlyCnt <= dlyReg;
    end else if (earlyFire) begin
      dlyRun <= 1'b0;
    end else if (dlyRun) begin
      dlyCnt <= dlyCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {txErrSt, rxErrSt, lateSt, earlySt} <= '0;
    end else begin
      txErrSt <= (txErrSt & ~strb.clrSum) | txErr;
      rxErrSt <= (rxErrSt & ~strb.clrSum) | rxErr;
      lateSt  <= (lateSt  & ~strb.clrSum) | rxFrameDone;
      earlySt <= (earlySt & ~strb.clrSum) | earlyFire;
    end
  end

  always_comb begin
    summary          = '0;
    summary[B_WAKE]  = ~wakeN;
    summary[B_QSTAT] = qStatIrq;
    summary[B_QOVF]  = qOvfIrq;
    summary[B_PHY]   = phyIrq;
    summary[B_STAT]  = |(txStat & txMask) | |(rxStat & rxMask);
    summary[B_TXERR] = txErrSt;
    summary[B_RXERR] = rxErrSt;
    summary[B_LATE]  = lateSt;
    summary[B_EARLY] = earlySt;
  end

  assign irq = |summary;

  always_comb begin
    rdData = '0;
    unique case (strb.rdSel)
      SEL_TXST:  rdData[HALF-1:0]  = txStat;
      SEL_TXMSK: rdData[HALF-1:0]  = txMask;
      SEL_RXST:  rdData[HALF-1:0]  = rxStat;
      SEL_RXMSK: rdData[HALF-1:0]  = rxMask;
      SEL_DLY:   rdData[DLY_W-1:0] = dlyReg;
      SEL_SUM:   rdData            = summary;
      default:   rdData            = '0;
    endcase
  end
endmodule

// File: rtl/stat_irq_top.sv
module stat_irq_top
  import stat_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               rdEn,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_CNT-1:0] rollEvt,
  input  logic               wakeN,
  input  logic               qStatIrq,
  input  logic               qOvfIrq,
  input  logic               phyIrq,
  input  logic               txErr,
  input  logic               rxErr,
  input  logic               rxFrameDone,
  input  logic               rxStart,
  output logic               irq
);
  strobe_t         strb;
  logic [HALF-1:0] txStat, rxStat;
  logic [DATA_W-1:0] summary;

  stat_irq_ctrl u_ctrl (
    .regAddr(regAddr), .wrEn(wrEn), .rdEn(rdEn), .strb(strb)
  );

  stat_irq_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdData(rdData),
    .rollEvt(rollEvt), .wakeN(wakeN), .qStatIrq(qStatIrq), .qOvfIrq(qOvfIrq),
    .phyIrq(phyIrq), .txErr(txErr), .rxErr(rxErr), .rxFrameDone(rxFrameDone),
    .rxStart(rxStart), .txStat(txStat), .rxStat(rxStat), .summary(summary),
    .irq(irq)
  );
endmodule

// File: rtl/stat_irq_chk.sv
module stat_irq_chk
  import stat_irq_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               wrEn,
  input logic               rdEn,
  input logic [DATA_W-1:0]  rdData,
  input logic [NUM_CNT-1:0] rollEvt,
  input logic [HALF-1:0]    txStat,
  input logic [HALF-1:0]    rxStat,
  input logic               irq
);
  localparam logic [DATA_W-1:0] RSV = 32'hFFE0_E67F;

  // R8: reserved summary bits never read as 1
  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regAddr == ADR_SUM) |-> ((rdData & RSV) == '0));

  // R2: a tx rollover always leaves its status bit set, even across a read
  assert_tx_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    rollEvt[0] |=> txStat[0]);

  // R2: a receive rollover on index 32 sets rx status bit 0
  assert_rx_map_R2: assert property (@(posedge clk) disable iff (!rstN)
    rollEvt[HALF] |=> rxStat[0]);

  // R3: read with no event empties the word
  assert_tx_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regAddr == ADR_TXST && rollEvt[HALF-1:0] == '0) |=> (txStat == '0));

  assert_rx_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regAddr == ADR_RXST && rollEvt[NUM_CNT-1:HALF] == '0) |=> (rxStat == '0));

  // R9: a write to a status address does not disturb it
  assert_ro_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !rdEn && regAddr == ADR_TXST && rollEvt[HALF-1:0] == '0)
      |=> (txStat == $past(txStat)));

  // R10: a summary read showing any bit implies the interrupt line is up
  assert_irq_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regAddr == ADR_SUM && rdData != '0) |-> irq);
endmodule

bind stat_irq_top stat_irq_chk u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .rdEn(rdEn),
  .rdData(rdData), .rollEvt(rollEvt), .txStat(txStat), .rxStat(rxStat),
  .irq(irq)
);

// File: tb/sim_stat_irq_top.sv
module sim_stat_irq_top;
  logic        clk = 0;
  logic        rstN = 0;
  logic [11:0] regAddr = '0;
  logic        wrEn = 0, rdEn = 0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [63:0] rollEvt = '0;
  logic wakeN = 1, qStatIrq = 0, qOvfIrq = 0, phyIrq = 0;
  logic txErr = 0, rxErr = 0, rxFrameDone = 0, rxStart = 0;
  logic irq;
  int nCmp = 0, nBad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stat_irq_top u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    @(negedge clk); regAddr = a; rdEn = 1; #1 v = rdData;
    @(negedge clk); rdEn = 0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); regAddr = a; wrData = d; wrEn = 1;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic pulseRoll(logic [63:0] e);
    @(negedge clk); rollEvt = e;
    @(negedge clk); rollEvt = '0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    rd(12'h1D0, v); check("R1 txst", v, 0);
    rd(12'h1D4, v); check("R1 txmsk", v, 0);
    rd(12'h1D8, v); check("R1 rxst", v, 0);
    rd(12'h1DC, v); check("R1 rxmsk", v, 0);
    rd(12'h1E0, v); check("R1 dly", v, 0);
    rd(12'h1E8, v); check("R1 sum", v, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic testMapAndClear();
    logic [31:0] v;
    pulseRoll(64'h0000_0004_8000_0001);
    repeat (2) @(negedge clk);
    check("R4 masked no irq", irq, 0);
    rd(12'h1D0, v); check("R2 tx sticky", v, 32'h8000_0001);
    rd(12'h1D0, v); check("R3 tx cleared", v, 0);
    rd(12'h1D8, v); check("R2 rx map n+32", v, 32'h0000_0004);
    rd(12'h1D8, v); check("R3 rx cleared", v, 0);
  endtask

  task automatic testSetWins();
    logic [31:0] v;
    pulseRoll(64'h1);
    @(negedge clk); regAddr = 12'h1D0; rdEn = 1; rollEvt = 64'h2; #1 v = rdData;
    @(negedge clk); rdEn = 0; rollEvt = '0;
    check("R3 read old", v, 32'h1);
    rd(12'h1D0, v); check("R3 set wins", v, 32'h2);
  endtask

  task automatic testMask();
    logic [31:0] v;
    wr(12'h1DC, 32'h0000_0010);
    rd(12'h1DC, v); check("R9 rxmsk readback", v, 32'h10);
    pulseRoll(64'h0000_0008_0000_0000);
    @(negedge clk);
    check("R4 unmasked bit blocked", irq, 0);
    pulseRoll(64'h0000_0010_0000_0000);
    @(negedge clk);
    check("R4 enabled bit irq", irq, 1);
    rd(12'h1E8, v); check("R4 sum bit16", v, 32'h0001_0000);
    rd(12'h1D8, v); check("R4 masked still latched", v, 32'h18);
    @(negedge clk);
    check("R10 irq drops", irq, 0);
    wr(12'h1DC, 0);
  endtask

  task automatic testLevels();
    logic [31:0] v;
    @(negedge clk); wakeN = 0; qStatIrq = 1; qOvfIrq = 1; phyIrq = 1;
    rd(12'h1E8, v); check("R5 levels", v, 32'h001E_0000);
    check("R10 irq level", irq, 1);
    @(negedge clk); wakeN = 1; qStatIrq = 0; qOvfIrq = 0; phyIrq = 0;
    #1 check("R5 levels off", irq, 0);
  endtask

  task automatic testSticky();
    logic [31:0] v;
    @(negedge clk); txErr = 1; rxErr = 1; rxFrameDone = 1;
    @(negedge clk); txErr = 0; rxErr = 0; rxFrameDone = 0;
    repeat (2) @(negedge clk);
    rd(12'h1E8, v); check("R6 sticky", v, 32'h0000_1900);
    check("R8 reserved", v & 32'hFFE0_E67F, 0);
    rd(12'h1E8, v); check("R6 cleared", v, 0);
  endtask

  task automatic testEarly();
    logic [31:0] v;
    wr(12'h1E0, 32'hABCD_0003);
    rd(12'h1E0, v); check("R9 dly 16b", v, 32'h0000_0003);
    @(negedge clk); rxStart = 1;
    @(negedge clk); rxStart = 0;
    repeat (3) @(negedge clk);
    check("R7 not yet", irq, 0);
    @(negedge clk);
    check("R7 fires at D+1", irq, 1);
    rd(12'h1E8, v); check("R7 bit7", v, 32'h0000_0080);
    rd(12'h1E8, v); check("R7 cleared", v, 0);
  endtask

  task automatic testRoWrite();
    logic [31:0] v;
    wr(12'h1D0, 32'hFFFF_FFFF);
    wr(12'h1D8, 32'hFFFF_FFFF);
    wr(12'h1E8, 32'hFFFF_FFFF);
    rd(12'h1D0, v); check("R9 txst ro", v, 0);
    rd(12'h1D8, v); check("R9 rxst ro", v, 0);
    rd(12'h1E8, v); check("R9 sum ro", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testMapAndClear();
    testSetWins();
    testMask();
    testLevels();
    testSticky();
    testEarly();
    testRoWrite();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule